// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block keeps the single reservation used by a single-core processor's exclusive word load and conditional word store. It sits next to the load/store unit and sees every decoded memory request in the cycle it issues: whether it is a load or a store, whether the instruction uses the immediate or the register form, the instruction word itself, and the effective address. A separate input reports that an interrupt or exception is being taken.

An exclusive access is a register-form request whose instruction word has its exclusive bit set. For such an access the block clears the two low address bits and suppresses the load/store unit's misalignment check. An exclusive load records the aligned address as the reservation and writes carry 0. An exclusive store compares its aligned address with the reservation. It writes carry 0 and enables the memory write on a match. On a mismatch it writes carry 1 and holds the write enable low. "No reservation" is encoded as an address of all ones. A word-aligned address can never take that value, so no separate valid flag is needed.

The outputs are combinational in the request cycle. The reservation register updates on the following clock edge.

Top module: `resv_monitor`

## Requirements
- R1: After reset the reservation holds the all-ones address. An exclusive store issued before any exclusive load therefore drives carry_we=1, carry_val=1 and mem_we=0.
- R2: A request is exclusive only when req_valid=1, req_imm_form=0 and bit 10 of req_instr is 1. An immediate-form request with bit 10 set behaves exactly like a plain access.
- R3: For an exclusive request, acc_addr equals req_addr with bits [1:0] forced to 0 and align_chk_en is 0. For any other valid request, acc_addr equals req_addr and align_chk_en is 1.
- R4: An exclusive load (req_store=0) drives carry_we=1, carry_val=0 and mem_we=0, and it stores the aligned address as the reservation at the next clock edge.
- R5: An exclusive store whose aligned address equals the reservation drives carry_we=1, carry_val=0 and mem_we=1.
- R6: An exclusive store whose aligned address differs from the reservation drives carry_we=1, carry_val=1 and mem_we=0 in the same cycle.
- R7: A successful exclusive store leaves the reservation unchanged, so a repeated exclusive store to the same word succeeds again.
- R8: A cycle with trap_evt=1 sets the reservation to all ones at the next edge.
- R9: When trap_evt=1 and an exclusive load occur in the same cycle, the reservation becomes all ones and not the load's address.
- R10: Plain loads and stores drive carry_we=0 and carry_val=0 and leave the reservation unchanged. A plain store drives mem_we=1 and a plain load drives mem_we=0.
- R11: byte_rev is 1 exactly when req_valid=1, req_imm_form=0 and bit 9 of req_instr is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A memory request issues this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_imm_form | input | 1 | Instruction uses the immediate form |
| req_instr | input | IW | Instruction word of the request |
| req_addr | input | AW | Effective address |
| trap_evt | input | 1 | Interrupt or exception taken this cycle |
| acc_addr | output | AW | Address to use for the access |
| align_chk_en | output | 1 | Misalignment check allowed for this access |
| byte_rev | output | 1 | Byte-reversed access selected |
| mem_we | output | 1 | Memory write enable for stores |
| carry_we | output | 1 | Carry flag is written this cycle |
| carry_val | output | 1 | Value written to carry (1 = conditional store failed) |

## Verification
Assertions check several rules on every cycle: the alignment of exclusive addresses, that a mismatching store never writes memory, that a trap always clears the reservation, that an exclusive load records its address, and that the reservation stays put when neither event occurs. The bench's scenarios are needed for the rules that depend on history. These are a store after reset, a store after a trap that came between load and store, a trap that arrives together with a load, and a repeated successful store. The bench exercises them with an 8-bit address and sweeps every address through a load, a matching store, a store to a neighbouring word and a repeat store.

// File: rtl/resv_pkg.sv
package resv_pkg;

  typedef struct packed {
    logic excl;
    logic rev;
    logic is_load;
    logic is_store;
  } lsu_dec_t;

endpackage

// File: rtl/resv_decode.sv
module resv_decode
  import resv_pkg::*;
#(
  parameter int IW       = 32,
  parameter int EXCL_BIT = 10,
  parameter int REV_BIT  = 9
) (
  input  logic          req_valid,
  input  logic          req_store,
  input  logic          req_imm_form,
  input  logic [IW-1:0] req_instr,
  output lsu_dec_t      dec
);

  logic reg_form;
  assign reg_form = req_valid && !req_imm_form;

  always_comb begin
    dec.excl     = reg_form && req_instr[EXCL_BIT];
    dec.rev      = reg_form && req_instr[REV_BIT];
    dec.is_load  = req_valid && !req_store;
    dec.is_store = req_valid && req_store;
  end

endmodule

// File: rtl/resv_addr_reg.sv
module resv_addr_reg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trap_evt,
  input  logic          set_en,
  input  logic [AW-1:0] set_addr,
  output logic [AW-1:0] resv
);

  localparam logic [AW-1:0] NONE = {AW{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        resv <= NONE;
    else if (trap_evt) resv <= NONE;
    else if (set_en)   resv <= set_addr;
  end

  assert_trap_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_evt |=> resv == NONE);

  assert_lwx_record_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !trap_evt) |=> resv == $past(set_addr));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !trap_evt) |=> $stable(resv));

endmodule

// File: rtl/resv_store_gate.sv
module resv_store_gate
  import resv_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  lsu_dec_t      dec,
  input  logic [AW-1:0] word_addr,
  input  logic [AW-1:0] resv,
  output logic          match,
  output logic          mem_we,
  output logic          carry_we,
  output logic          carry_val
);

  logic xs_fire, xl_fire;
  assign xs_fire = dec.excl && dec.is_store;
  assign xl_fire = dec.excl && dec.is_load;
  assign match   = (word_addr == resv);

  always_comb begin
    mem_we    = 1'b0;
    carry_we  = 1'b0;
    carry_val = 1'b0;
    if (xs_fire) begin
      carry_we  = 1'b1;
      carry_val = !match;
      mem_we    = match;
    end else if (xl_fire) begin
      carry_we  = 1'b1;
    end else if (dec.is_store) begin
      mem_we    = 1'b1;
    end
  end

  assert_swx_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xs_fire && !match) |-> (!mem_we && carry_val));

  assert_swx_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xs_fire && match) |-> (mem_we && !carry_val));

  assert_lwx_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xl_fire |-> (carry_we && !carry_val && !mem_we));

  assert_plain_carry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !dec.excl |-> !carry_we);

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int AW       = 32,
  parameter int IW       = 32,
  parameter int EXCL_BIT = 10,
  parameter int REV_BIT  = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_store,
  input  logic          req_imm_form,
  input  logic [IW-1:0] req_instr,
  input  logic [AW-1:0] req_addr,
  input  logic          trap_evt,
  output logic [AW-1:0] acc_addr,
  output logic          align_chk_en,
  output logic          byte_rev,
  output logic          mem_we,
  output logic          carry_we,
  output logic          carry_val
);

  function automatic logic [AW-1:0] word_of(input logic [AW-1:0] a);
    return {a[AW-1:2], 2'b00};
  endfunction

  lsu_dec_t      dec;
  logic [AW-1:0] word_addr;
  logic [AW-1:0] resv;
  logic          match;
  logic          resv_set;

  resv_decode #(.IW(IW), .EXCL_BIT(EXCL_BIT), .REV_BIT(REV_BIT)) u_dec (
    .req_valid    (req_valid),
    .req_store    (req_store),
    .req_imm_form (req_imm_form),
    .req_instr    (req_instr),
    .dec          (dec)
  );

  assign word_addr    = word_of(req_addr);
  assign acc_addr     = dec.excl ? word_addr : req_addr;
  assign align_chk_en = req_valid && !dec.excl;
  assign byte_rev     = dec.rev;
  assign resv_set     = dec.excl && dec.is_load;

  resv_addr_reg #(.AW(AW)) u_resv (
    .clk      (clk),
    .rst_n    (rst_n),
    .trap_evt (trap_evt),
    .set_en   (resv_set),
    .set_addr (word_addr),
    .resv     (resv)
  );

  resv_store_gate #(.AW(AW)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec       (dec),
    .word_addr (word_addr),
    .resv      (resv),
    .match     (match),
    .mem_we    (mem_we),
    .carry_we  (carry_we),
    .carry_val (carry_val)
  );

  assert_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dec.excl |-> (acc_addr[1:0] == 2'b00 && !align_chk_en));

  assert_sentinel_never_matches_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (resv == {AW{1'b1}}) |-> !match);

endmodule

// File: tb/resv_monitor_tb.sv
module resv_monitor_tb;

  localparam int AW = 8;
  localparam int IW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_store = 1'b0, req_imm_form = 1'b0;
  logic [IW-1:0] req_instr = '0;
  logic [AW-1:0] req_addr = '0;
  logic          trap_evt = 1'b0;
  logic [AW-1:0] acc_addr;
  logic          align_chk_en, byte_rev, mem_we, carry_we, carry_val;

  int checks = 0;
  int errors = 0;
  logic [AW-1:0] model = '1;
  bit done = 0;

  always #10 clk = ~clk;

  resv_monitor #(.AW(AW), .IW(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_imm_form(req_imm_form), .req_instr(req_instr), .req_addr(req_addr),
    .trap_evt(trap_evt), .acc_addr(acc_addr), .align_chk_en(align_chk_en),
    .byte_rev(byte_rev), .mem_we(mem_we), .carry_we(carry_we), .carry_val(carry_val)
  );

  task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One request cycle: drive at negedge, compare after settling, model updates at posedge.
  task automatic op(input bit v, input bit st, input bit x, input bit imm, input bit rev,
                    input logic [AW-1:0] a, input bit tr, input string tag);
    logic [AW-1:0] wa, e_acc;
    bit ex, e_chk, e_rev, e_mwe, e_cwe, e_cv;
    @(negedge clk);
    req_valid = v; req_store = st; req_imm_form = imm; req_addr = a; trap_evt = tr;
    req_instr = 32'hA5A5_0000 ^ (32'(x) << 10) ^ (32'(rev) << 9) ^ 32'(a);
    req_instr[10] = x; req_instr[9] = rev;
    #2;
    ex    = v && !imm && x;
    wa    = a & ~8'd3;
    e_acc = ex ? wa : a;
    e_chk = v && !ex;
    e_rev = v && !imm && rev;
    e_mwe = 0; e_cwe = 0; e_cv = 0;
    if (ex && st)      begin e_cwe = 1; e_cv = (model != wa); e_mwe = (model == wa); end
    else if (ex)       begin e_cwe = 1; end
    else if (v && st)  begin e_mwe = 1; end
    check(tag, {acc_addr, align_chk_en, byte_rev, mem_we, carry_we, carry_val},
               {e_acc, e_chk, e_rev, e_mwe, e_cwe, e_cv});
    if (tr)             model = '1;
    else if (ex && !st) model = wa;
    @(posedge clk);
    #1;
    req_valid = 0; trap_evt = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    // R1: idle outputs during reset
    check("R1 reset idle", {acc_addr, align_chk_en, byte_rev, mem_we, carry_we, carry_val}, 13'h0);
    @(negedge clk) rst_n = 1'b1;
    // R1: swx right after reset fails
    op(1, 1, 1, 0, 0, 8'h40, 0, "R1 swx after reset");
    // sweep every address: lwx, matching swx, neighbouring word swx, repeat swx
    for (int a = 0; a < 256; a++) begin
      op(1, 0, 1, 0, 0, 8'(a), 0, "R3 R4 lwx");
      op(1, 1, 1, 0, 0, 8'(a ^ 1), 0, "R5 swx match");
      op(1, 1, 1, 0, 0, 8'(a ^ 4), 0, "R6 swx mismatch");
      op(1, 1, 1, 0, 0, 8'(a), 0, "R7 swx repeat");
    end
    // R8: trap between lwx and swx
    op(1, 0, 1, 0, 0, 8'h24, 0, "R8 lwx");
    op(0, 0, 0, 0, 0, 8'h00, 1, "R8 trap");
    op(1, 1, 1, 0, 0, 8'h24, 0, "R8 swx after trap");
    // R9: trap coincident with lwx
    op(1, 0, 1, 0, 0, 8'h88, 1, "R9 lwx with trap");
    op(1, 1, 1, 0, 0, 8'h88, 0, "R9 swx");
    // R10 and R2: plain accesses leave reservation and carry alone
    op(1, 0, 1, 0, 0, 8'h31, 0, "R10 lwx");
    op(1, 0, 0, 0, 0, 8'h77, 0, "R10 plain load");
    op(1, 1, 0, 0, 0, 8'h53, 0, "R10 plain store");
    op(1, 0, 1, 1, 0, 8'h93, 0, "R2 imm-form load bit10");
    op(1, 1, 1, 1, 0, 8'h95, 0, "R2 imm-form store bit10");
    op(0, 1, 1, 0, 0, 8'h32, 0, "R2 invalid request");
    op(1, 1, 1, 0, 0, 8'h32, 0, "R10 swx reservation kept");
    // R11: byte-reverse decode
    op(1, 0, 0, 0, 1, 8'h12, 0, "R11 rev reg-form");
    op(1, 1, 0, 1, 1, 8'h13, 0, "R11 rev imm-form");
    op(1, 1, 1, 0, 1, 8'h30, 0, "R11 rev with swx");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule